// File: doc/BRIEF.md
# Pad hold controller

This block decides when the chip's digital pads must keep their output values frozen. When the power-mode sequencer signals entry into sleep or ultra-deep sleep, the pad hold engages at once. The pads then keep the values they drove just before entry. When the sequencer later reports that wakeup has completed, the freeze either lifts by itself or stays in place until software releases it. Software does this with two separate writes, in order.

Configuration arrives as a single-cycle write strobe with a four-bit data word. Two bits of the word select the release policy. The other two bits are one-shot actions that make up the manual release sequence. The hold drive is replicated once per pad group so that each group gets its own register. A status output stays high for one extra cycle after release, so that logic watching it cannot miss a short freeze.

Top module: `pad_hold_ctrl`

## Requirements
- R1: A pulse on `slp_enter` or on `udslp_enter` sets every bit of `pad_le` to 1 in the cycle after the pulse, whatever state the block was in.
- R2: If the policy bits are keep=0 and auto=1 when `wake_done` pulses during the low-power period, `pad_le` returns to 0 in the cycle after the pulse.
- R3: With any other policy, `pad_le` stays 1 after `wake_done` until two writes arrive: one with the arm bit set, then a later one with the commit bit set. `pad_le` returns to 0 in the cycle after the commit write.
- R4: After reset, both policy bits are 0, so the release is manual. `pad_le` and `hold_status` are 0.
- R5: keep=1 selects manual release even when auto=1.
- R6: A commit write releases nothing unless an arm is pending from an earlier write. Every commit write clears the pending arm. A word with both arm and commit set counts as a commit and is judged against the arm state held before that write.
- R7: `hold_status` is 1 in every cycle that `pad_le` is 1. It stays 1 for exactly one cycle after `pad_le` falls, then reads 0.
- R8: If a commit write coincides with the low-power period (including the cycle of `wake_done`), it releases nothing but still consumes the pending arm. If an entry pulse falls in the same cycle as `wake_done` or a commit, the entry wins and the hold stays engaged.
- R9: A synchronous reset clears the hold, the status, the pending arm and both policy bits, even in the middle of a freeze.
- R10: Write word layout: bit 0 keep, bit 1 auto, bit 2 arm, bit 3 commit. Every write reloads both policy bits from bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slp_enter | input | 1 | One-cycle pulse: sleep entry |
| udslp_enter | input | 1 | One-cycle pulse: ultra-deep sleep entry |
| wake_done | input | 1 | One-cycle pulse: wakeup completed |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | CFG_W | Control word (keep, auto, arm, commit) |
| pad_le | output | N_PAD_GRP | Pad latch enable, one replica per pad group |
| hold_status | output | 1 | High while frozen plus one cycle after release |

## Verification
The two events that can fall in the same cycle are wakeup completion and a software commit write. An entry pulse can also coincide with a commit write or with `wake_done`. The bench provokes each of these by driving the two pulses on the same clock edge after first arming the release. It then judges the result in two ways. It checks that the hold is still engaged in the following cycle. It also issues a further commit alone and checks that the pad drive does not drop, which proves the colliding commit consumed the arm.

// File: rtl/pad_hold_pkg.sv
package pad_hold_pkg;

  localparam int CFG_W      = 4;
  localparam int BIT_KEEP   = 0;
  localparam int BIT_AUTO   = 1;
  localparam int BIT_ARM    = 2;
  localparam int BIT_COMMIT = 3;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_LOWPWR = 2'd1,
    ST_KEEP   = 2'd2
  } hold_state_e;

  typedef struct packed {
    logic keep;
    logic autorel;
  } hold_mode_t;

endpackage

// File: rtl/pad_hold_cfg.sv
module pad_hold_cfg
  import pad_hold_pkg::*;
#(
  parameter int CFG_W = pad_hold_pkg::CFG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output hold_mode_t       mode,
  output logic             release_req,
  output logic             commit_wr
);

  logic armed_q;

  assign commit_wr   = we & wdata[BIT_COMMIT];
  assign release_req = commit_wr & armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= '0;
      armed_q <= 1'b0;
    end else if (we) begin
      mode.keep    <= wdata[BIT_KEEP];
      mode.autorel <= wdata[BIT_AUTO];
      if (wdata[BIT_COMMIT]) begin
        armed_q <= 1'b0;
      end else if (wdata[BIT_ARM]) begin
        armed_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pad_hold_fsm.sv
module pad_hold_fsm
  import pad_hold_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enter,
  input  logic       wake,
  input  hold_mode_t mode,
  input  logic       release_req,
  output logic       hold_next,
  output logic       hold_now
);

  hold_state_e state_q, state_d;
  logic        auto_ok;

  assign auto_ok = mode.autorel & ~mode.keep;

  always_comb begin
    state_d = state_q;
    if (enter) begin
      state_d = ST_LOWPWR;
    end else begin
      unique case (state_q)
        ST_LOWPWR: if (wake)        state_d = auto_ok ? ST_RUN : ST_KEEP;
        ST_KEEP:   if (release_req) state_d = ST_RUN;
        default:                    state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  assign hold_next = (state_d != ST_RUN);
  assign hold_now  = (state_q != ST_RUN);

endmodule

// File: rtl/pad_hold_out.sv
module pad_hold_out #(
  parameter int N_PAD_GRP = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hold_next,
  input  logic                 hold_now,
  output logic [N_PAD_GRP-1:0] pad_le,
  output logic                 status
);

  for (genvar g = 0; g < N_PAD_GRP; g++) begin : g_rep
    always_ff @(posedge clk) begin
      if (rst) pad_le[g] <= 1'b0;
      else     pad_le[g] <= hold_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status <= 1'b0;
    else     status <= hold_next | hold_now;
  end

endmodule

// File: rtl/pad_hold_ctrl.sv
module pad_hold_ctrl
  import pad_hold_pkg::*;
#(
  parameter int N_PAD_GRP = 4,
  parameter int CFG_W     = pad_hold_pkg::CFG_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 slp_enter,
  input  logic                 udslp_enter,
  input  logic                 wake_done,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [N_PAD_GRP-1:0] pad_le,
  output logic                 hold_status
);

  hold_mode_t mode;
  logic       release_req;
  logic       commit_wr;
  logic       hold_next;
  logic       hold_now;
  logic       enter;

  assign enter = slp_enter | udslp_enter;

  pad_hold_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .we          (cfg_we),
    .wdata       (cfg_wdata),
    .mode        (mode),
    .release_req (release_req),
    .commit_wr   (commit_wr)
  );

  pad_hold_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .enter       (enter),
    .wake        (wake_done),
    .mode        (mode),
    .release_req (release_req),
    .hold_next   (hold_next),
    .hold_now    (hold_now)
  );

  pad_hold_out #(.N_PAD_GRP(N_PAD_GRP)) u_out (
    .clk       (clk),
    .rst       (rst),
    .hold_next (hold_next),
    .hold_now  (hold_now),
    .pad_le    (pad_le),
    .status    (hold_status)
  );

endmodule

// File: rtl/pad_hold_chk.sv
module pad_hold_chk #(
  parameter int N_PAD_GRP = 4,
  parameter int CFG_W     = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 slp_enter,
  input logic                 udslp_enter,
  input logic                 wake_done,
  input logic                 cfg_we,
  input logic [CFG_W-1:0]     cfg_wdata,
  input logic [N_PAD_GRP-1:0] pad_le,
  input logic                 hold_status
);

  assert_entry_holds_R1: assert property (@(posedge clk) disable iff (rst)
    (slp_enter || udslp_enter) |=> (pad_le == '1));

  assert_replicas_agree_R1: assert property (@(posedge clk) disable iff (rst)
    (pad_le == '0) || (pad_le == '1));

  assert_status_while_held_R7: assert property (@(posedge clk) disable iff (rst)
    pad_le[0] |-> hold_status);

  assert_status_tail_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(pad_le[0]) ##1 !pad_le[0]) |-> !hold_status);

  assert_release_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(pad_le[0]) |-> ($past(wake_done) || $past(cfg_we && cfg_wdata[3]) || $past(rst)));

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (pad_le == '0 && !hold_status));

endmodule

bind pad_hold_ctrl pad_hold_chk #(.N_PAD_GRP(N_PAD_GRP), .CFG_W(CFG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .slp_enter   (slp_enter),
  .udslp_enter (udslp_enter),
  .wake_done   (wake_done),
  .cfg_we      (cfg_we),
  .cfg_wdata   (cfg_wdata),
  .pad_le      (pad_le),
  .hold_status (hold_status)
);

// File: tb/tb_pad_hold_ctrl.sv
`timescale 1ns/1ps
module tb_pad_hold_ctrl;

  localparam int NG = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slp_enter = 1'b0, udslp_enter = 1'b0, wake_done = 1'b0, cfg_we = 1'b0;
  logic [3:0]    cfg_wdata = '0;
  logic [NG-1:0] pad_le;
  logic          hold_status;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  pad_hold_ctrl #(.N_PAD_GRP(NG)) dut (
    .clk(clk), .rst(rst), .slp_enter(slp_enter), .udslp_enter(udslp_enter),
    .wake_done(wake_done), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pad_le(pad_le), .hold_status(hold_status)
  );

  // {slp, udslp, wake, we, wdata[3:0], exp_hold, exp_status}
  localparam int NV = 20;
  localparam logic [9:0] VEC [0:NV-1] = '{
    10'b0_0_0_0_0000_00, // R4 idle after reset
    10'b1_0_0_0_0000_11, // R1 sleep entry
    10'b0_0_0_0_0000_11, // R1 still held
    10'b0_0_1_0_0000_11, // R4 default manual: held after wake
    10'b0_0_0_1_1000_11, // R6 commit without arm
    10'b0_0_0_1_0100_11, // R3 arm
    10'b0_0_0_1_1000_01, // R3 commit releases, R7 status tail
    10'b0_0_0_0_0000_00, // R7 status clears
    10'b0_0_0_1_0010_00, // R10 select auto
    10'b0_1_0_0_0000_11, // R1 ultra-deep entry
    10'b0_0_1_0_0000_01, // R2 auto release
    10'b0_0_0_0_0000_00, // R7
    10'b0_0_0_1_0011_00, // R5 keep+auto
    10'b1_0_0_0_0000_11, // R1
    10'b0_0_1_0_0000_11, // R5 keep forces manual
    10'b0_0_0_1_1111_11, // R6 arm+commit in one word, not armed before
    10'b0_0_0_1_1011_11, // R6 arm was not left pending
    10'b0_0_0_1_0111_11, // R3 arm
    10'b0_0_0_1_1011_01, // R3 commit releases
    10'b0_0_0_0_0000_00  // R7
  };

  task automatic check(input logic eh, input logic es, input string tag);
    checks++;
    if (pad_le !== {NG{eh}} || hold_status !== es) begin
      errors++;
      $display("FAIL %s: pad_le=%b status=%b expected pad_le=%b status=%b",
               tag, pad_le, hold_status, {NG{eh}}, es);
    end
  endtask

  task automatic step(input logic s, input logic u, input logic w,
                      input logic we, input logic [3:0] d);
    slp_enter = s; udslp_enter = u; wake_done = w; cfg_we = we; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    slp_enter = 0; udslp_enter = 0; wake_done = 0; cfg_we = 0; cfg_wdata = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    check(1'b0, 1'b0, "R4 reset state");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:2]);
      check(VEC[i][1], VEC[i][0], $sformatf("R1/R2/R3/R5/R6/R7 vector %0d", i));
    end

    // wake_done and armed commit in the same cycle
    do_reset();
    check(1'b0, 1'b0, "R9 reset clears");
    step(0, 0, 0, 1, 4'b0100);
    step(1, 0, 0, 0, 4'b0000);
    step(0, 0, 1, 1, 4'b1000);
    check(1'b1, 1'b1, "R8 commit with wake ignored");
    step(0, 0, 0, 1, 4'b1000);
    check(1'b1, 1'b1, "R8 arm consumed by colliding commit");
    step(0, 0, 0, 1, 4'b0100);
    step(0, 0, 0, 1, 4'b1000);
    check(1'b0, 1'b1, "R3 release after fresh arm");
    step(0, 0, 0, 0, 4'b0000);

    // entry and armed commit in the same cycle
    step(1, 0, 0, 0, 4'b0000);
    step(0, 0, 1, 0, 4'b0000);
    step(0, 0, 0, 1, 4'b0100);
    step(1, 0, 0, 1, 4'b1000);
    check(1'b1, 1'b1, "R8 entry wins over commit");
    step(0, 0, 1, 0, 4'b0000);
    step(0, 0, 0, 1, 4'b1000);
    check(1'b1, 1'b1, "R8 manual hold after colliding commit");
    step(0, 0, 0, 1, 4'b0100);
    step(0, 0, 0, 1, 4'b1000);
    check(1'b0, 1'b1, "R3 release");
    step(0, 0, 0, 0, 4'b0000);

    // entry and wake in the same cycle, auto policy
    step(0, 0, 0, 1, 4'b0010);
    step(1, 0, 0, 0, 4'b0000);
    step(1, 0, 1, 0, 4'b0000);
    check(1'b1, 1'b1, "R8 entry wins over wake");
    step(0, 0, 1, 0, 4'b0000);
    check(1'b0, 1'b1, "R2 auto release later");
    check(1'b0, 1'b1, "R7 same cycle status high");
    step(0, 0, 0, 0, 4'b0000);
    check(1'b0, 1'b0, "R7 status low after one cycle");

    // reset in the middle of a freeze clears policy
    step(1, 0, 0, 0, 4'b0000);
    check(1'b1, 1'b1, "R1 held before reset");
    do_reset();
    check(1'b0, 1'b0, "R9 reset during hold");
    step(0, 1, 0, 0, 4'b0000);
    step(0, 0, 1, 0, 4'b0000);
    check(1'b1, 1'b1, "R9 policy back to manual");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule